// File: doc/BRIEF.md
# Shared Timer Pin Function Multiplexer

This block sits between one bidirectional timer pin and a pair of timers, called A and B. The pin has two roles. In input mode, the block watches the pin for rising edges and turns each one into a count pulse for timer B. In output mode, the block drives the pin with a signal built from the timers' divide-by-2 underflow toggles.

A two-bit control register picks the role and the output source. The output source is either timer A's toggle alone, or the AND of timer A's toggle and timer B's toggle. The pin input passes through a synchroniser before edge detection, so the raw pad level may be fully asynchronous to the clock.

The pad output value is registered. Each timer is expected to hand over its toggle as a level that flips once per underflow.

Top module: `timer_pin_mux`

## Requirements
- R1: After reset the pin is in input mode (`pin_oe` = 0), the output source is timer A alone, `pin_out` is 0 and `cnt_pulse_b` is 0.
- R2: A write (`cfg_we` = 1) stores `cfg_wdata[0]` as the direction bit, where 1 means output mode, and `cfg_wdata[1]` as the source bit, where 1 means AND. `pin_oe` shows the new direction from the cycle after the write edge.
- R3: In input mode, a rising edge on `pin_in` sampled at clock edge k makes `cnt_pulse_b` high for exactly the cycle that follows edge k+1.
- R4: A pin held high, or a falling edge, produces no further pulse. Each rising edge gives exactly one single-cycle pulse.
- R5: In output mode `cnt_pulse_b` stays 0 whatever the pin does.
- R6: With the source bit at 0, `pin_out` equals the value `tgl_a` had at the previous clock edge.
- R7: With the source bit at 1, `pin_out` equals `tgl_a & tgl_b` as sampled at the previous clock edge.
- R8: While `cfg_we` is 0, the values on `cfg_wdata` have no effect on the direction or the output source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | bit0: 1 = output mode; bit1: 1 = AND source |
| pin_in | input | 1 | Level read back from the pad (asynchronous) |
| tgl_a | input | 1 | Timer A divide-by-2 underflow toggle |
| tgl_b | input | 1 | Timer B divide-by-2 underflow toggle |
| pin_out | output | 1 | Registered value to drive on the pad |
| pin_oe | output | 1 | Pad output enable, 1 in output mode |
| cnt_pulse_b | output | 1 | Single-cycle count pulse for timer B |

## Verification
The hardest case to reach is a change of mode while the synchroniser still holds a rising edge in flight. If the pin rose just before the block is switched back to input mode, a pulse appears that belongs to an edge seen while output mode was active. The stimulus toggles the pin in the cycles around each direction write, and the cycle model tracks the synchroniser history, so the pulse timing is compared in every cycle rather than only in quiet periods.

// File: rtl/timer_pin_mux.sv
module timer_pin_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  input  logic       pin_in,
  input  logic       tgl_a,
  input  logic       tgl_b,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       cnt_pulse_b
);

  localparam int TOP = SYNC_STAGES - 1;

  logic                   drive_q;
  logic                   and_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   out_q;
  logic                   src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      and_q   <= 1'b0;
    end else if (cfg_we) begin
      drive_q <= cfg_wdata[0];
      and_q   <= cfg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], pin_in};
      last_q <= sync_q[TOP];
    end
  end

  assign cnt_pulse_b = sync_q[TOP] & ~last_q & ~drive_q;

  assign src = and_q ? (tgl_a & tgl_b) : tgl_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= src;
  end

  assign pin_out = out_q;
  assign pin_oe  = drive_q;

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (pin_oe == $past(cfg_wdata[0])));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(pin_oe));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse_b |=> !cnt_pulse_b);

  assert_no_pulse_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !cnt_pulse_b);

  assert_out_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !and_q |=> (pin_out == $past(tgl_a)));

  assert_out_and_R7: assert property (@(posedge clk) disable iff (!rst_n)
    and_q |=> (pin_out == $past(tgl_a & tgl_b)));

endmodule

// File: tb/tb_timer_pin_mux.sv
module tb_timer_pin_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic pin_in = 1'b0;
  logic tgl_a = 1'b0;
  logic tgl_b = 1'b0;
  logic pin_out, pin_oe, cnt_pulse_b;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  string req = "R1";
  bit done = 0;

  bit m_oe = 0, m_and = 0, m_out = 0;
  bit hist[$];

  always #4 clk = ~clk;

  timer_pin_mux dut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe = 0; m_and = 0; m_out = 0;
      hist = {0, 0, 0};
    end else begin
      m_out = m_and ? (tgl_a & tgl_b) : tgl_a;
      if (cfg_we) begin m_oe = cfg_wdata[0]; m_and = cfg_wdata[1]; end
      hist.push_back(pin_in);
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  function automatic bit exp_pulse();
    int n = hist.size();
    return !m_oe && hist[n-2] && !hist[n-3];
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(req, "pin_oe", pin_oe, m_oe);
    chk(req, "pin_out", pin_out, m_out);
    chk(req, "cnt_pulse_b", cnt_pulse_b, exp_pulse());
    if (cnt_pulse_b) pulses++;
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] v);
    cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0; cfg_wdata = 2'b00;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1", "reset pin_oe", pin_oe, 0);
    chk("R1", "reset pin_out", pin_out, 0);
    chk("R1", "reset pulse", cnt_pulse_b, 0);
    rst_n = 1;
    step(2);

    req = "R3";
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      pin_in = 1; step(1 + i % 3); pin_in = 0; step(2 + i % 2);
    end
    step(4);
    chk("R3", "pulse count for 6 edges", pulses, 6);

    req = "R4";
    pulses = 0;
    pin_in = 1; step(12); pin_in = 0; step(6);
    chk("R4", "pulse count for one held edge", pulses, 1);

    req = "R8";
    cfg_wdata = 2'b11; step(3); cfg_wdata = 2'b00;
    chk("R8", "pin_oe without write", pin_oe, 0);

    req = "R2";
    wr(2'b01);
    chk("R2", "pin_oe after write", pin_oe, 1);

    req = "R5";
    pulses = 0;
    for (int i = 0; i < 5; i++) begin pin_in = 1; step(2); pin_in = 0; step(2); end
    chk("R5", "pulses in output mode", pulses, 0);

    req = "R6";
    for (int i = 0; i < 40; i++) begin
      tgl_a = $urandom_range(0, 1); tgl_b = $urandom_range(0, 1); step();
    end

    req = "R7";
    wr(2'b11);
    for (int i = 0; i < 40; i++) begin
      tgl_a = $urandom_range(0, 1); tgl_b = $urandom_range(0, 1); step();
    end

    req = "R3";
    for (int i = 0; i < 12; i++) begin
      pin_in = i[0];
      cfg_we = 1; cfg_wdata = {1'b0, i[1]};
      step();
      cfg_we = 0;
      step(i % 3);
    end
    pin_in = 0; step(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule